// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block is a byte-wide, bus-programmed timer with three independent 16-bit down-counters. Software writes a control byte to a shared control address. The byte picks a channel, an access type and a counting mode. Software then loads the channel's reload value through the channel's own data address, one byte or two bytes per load. Each channel drives one output pin. The pin behaves as a terminal-count flag, a one-clock pulse train or a square wave, depending on the mode.

Counting is paced by a single-cycle count-enable strobe, `cnt_tick`, in the system clock domain. The timer has no clock of its own. Software can read a channel's live count at any time. It can also issue a latch command that freezes a snapshot for a coherent two-byte read while the counter keeps running.

Top module: `ivt_timer`

## Requirements
- R1: After reset every output is high, every channel is stopped, a read of any channel returns 0x00, and `cnt_tick` changes nothing until a channel is loaded.
- R2: A write to address 3 is a control byte. Bits 7:6 pick the channel (00, 01 or 10); the value 11 makes the whole byte have no effect. Bits 5:4 give the access type: 00 latch, 01 low byte only, 10 high byte only, 11 low byte then high byte. Bits 3:1 give the mode. Bit 0 is ignored, and counting is always binary.
- R3: Data writes to address 0, 1 or 2 go to that channel. In low-then-high access the first write sets the low byte and the second sets the high byte. The count loads on the clock edge that takes the final byte. A tick in that same cycle is not counted, and each later tick decrements the count by 1.
- R4: In low-only access one write loads the value with the high byte 0. In high-only access one write loads the value with the low byte 0. In both cases the count starts at once.
- R5: Mode 000 (terminal count): the output goes low on the control write. It goes high after exactly N ticks from the load and stays high while the count keeps decrementing and wrapping.
- R6: Modes 010 and 110 (rate generator): the output is high after the load. It is low for exactly one tick interval, the one in which the count equals 1. It repeats with a period of N ticks.
- R7: Modes 011 and 111 (square wave): in each period of N ticks the output is high for ceil(N/2) ticks and then low for floor(N/2) ticks.
- R8: A reload value of 0 counts as 65536.
- R9: A latch command (access type 00) copies the current count. The counter keeps decrementing. Further latch commands are ignored until the copy has been read out.
- R10: A read returns the latched copy if one is held, and the live count otherwise. In low-then-high access, reads alternate between the low byte and the high byte, starting with the low byte, and the copy is released after the high byte. In single-byte access each read returns the selected byte and releases the copy.
- R11: A control byte for a channel stops the channel, resets its write and read byte order to the low byte, and discards any held copy.
- R12: Control, data and read traffic to one channel leaves the other channels' counts and outputs unchanged.
- R13: Modes 001, 100 and 101 keep the output high and never start the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte; the byte order advances at the end of the cycle |
| bus_addr | input | 2 | 0 to 2 select a channel, 3 selects the control address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during the `bus_rd` cycle |
| cnt_tick | input | 1 | Count-enable strobe |
| tmr_out | output | 3 | One timer output per channel |

## Verification
The bench checks the exact tick on which the terminal-count output rises. It does this for a value of 0, which takes 65536 ticks, and for a load whose final byte arrives together with a tick. A design that counted that tick, or stopped at 0, would raise the output early.

The bench checks the low slot of the rate generator and the high and low split of the square wave for odd and even N. An off-by-one count would shift the output levels the bench samples.

For the snapshot path, the bench issues a second latch command while a copy is held, and reads the channel live after the copy is released. A design that let the second latch overwrite the copy, or never released it, would return stale bytes.

The bench writes half a word and then reprograms the channel. A design that kept its byte order across the control write would put the next byte in the high half.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_WORD  = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_TC   = 2'd1,
        OP_RATE = 2'd2,
        OP_SQ   = 2'd3
    } op_e;

    function automatic op_e decode_mode(input logic [2:0] m);
        case (m)
            3'b000:         return OP_TC;
            3'b010, 3'b110: return OP_RATE;
            3'b011, 3'b111: return OP_SQ;
            default:        return OP_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/ivt_ctrl_dec.sv
module ivt_ctrl_dec
    import ivt_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int BYTE_W = 8
) (
    input  logic              wr_ctl_i,
    input  logic [BYTE_W-1:1] ctl_i,
    output logic [NUM_CH-1:0] prog_o,
    output logic [NUM_CH-1:0] latch_o,
    output acc_e              acc_o,
    output op_e               op_o
);
    localparam int SEL_LSB  = BYTE_W - 2;
    localparam int ACC_LSB  = BYTE_W - 4;
    localparam int MODE_LSB = 1;

    logic [1:0] sel;

    assign sel   = ctl_i[SEL_LSB +: 2];
    assign acc_o = acc_e'(ctl_i[ACC_LSB +: 2]);
    assign op_o  = decode_mode(ctl_i[MODE_LSB +: 3]);

    // select value 3 matches no channel, so such a byte is dropped (R2)
    for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
        logic hit;
        assign hit        = wr_ctl_i && (sel == 2'(i));
        assign prog_o[i]  = hit && (acc_o != ACC_LATCH);
        assign latch_o[i] = hit && (acc_o == ACC_LATCH);
    end
endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
    import ivt_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_i,
    input  logic                  prog_i,
    input  acc_e                  acc_i,
    input  op_e                   op_i,
    input  logic                  wr_i,
    input  logic [BYTE_W-1:0]     wdata_i,
    output logic [2*BYTE_W-1:0]   count_o,
    output acc_e                  acc_o,
    output logic                  out_o
);
    localparam int CNT_W = 2 * BYTE_W;

    typedef struct packed {
        acc_e             acc;
        op_e              op;
        logic [CNT_W-1:0] reload;
        logic             wr_hi;
        logic [CNT_W-1:0] count;
        logic             run;
        logic             out;
    } ch_state_t;

    ch_state_t st_q, st_d;

    // a count of 0 stands for 2**CNT_W (R8)
    function automatic logic wave_level(input op_e op,
                                        input logic [CNT_W-1:0] cnt,
                                        input logic [CNT_W-1:0] rel);
        logic [CNT_W:0] e_c;
        logic [CNT_W:0] e_r;
        e_c = {cnt == '0, cnt};
        e_r = {rel == '0, rel};
        case (op)
            OP_RATE: return e_c != (CNT_W+1)'(1);
            OP_SQ:   return e_c > (e_r >> 1);
            default: return 1'b1;
        endcase
    endfunction

    always_comb begin
        logic [CNT_W-1:0] nxt;
        logic             done;
        st_d = st_q;
        nxt  = st_q.reload;
        done = 1'b0;
        if (prog_i) begin
            st_d.acc   = acc_i;
            st_d.op    = op_i;
            st_d.wr_hi = 1'b0;
            st_d.run   = 1'b0;
            st_d.out   = (op_i != OP_TC);
        end else if (wr_i) begin
            case (st_q.acc)
                ACC_LO: begin
                    nxt  = {{BYTE_W{1'b0}}, wdata_i};
                    done = 1'b1;
                end
                ACC_HI: begin
                    nxt  = {wdata_i, {BYTE_W{1'b0}}};
                    done = 1'b1;
                end
                default: begin
                    if (!st_q.wr_hi) begin
                        nxt[BYTE_W-1:0] = wdata_i;
                        st_d.wr_hi      = 1'b1;
                    end else begin
                        nxt[CNT_W-1:BYTE_W] = wdata_i;
                        st_d.wr_hi          = 1'b0;
                        done                = 1'b1;
                    end
                end
            endcase
            st_d.reload = nxt;
            if (done && st_q.op != OP_IDLE) begin
                st_d.count = nxt;
                st_d.run   = 1'b1;
                st_d.out   = (st_q.op == OP_TC) ? 1'b0 : wave_level(st_q.op, nxt, nxt);
            end
        end else if (st_q.run && tick_i) begin
            if (st_q.op == OP_TC) begin
                st_d.count = st_q.count - 1'b1;
                if (st_q.count == CNT_W'(1)) st_d.out = 1'b1;
            end else begin
                st_d.count = (st_q.count == CNT_W'(1)) ? st_q.reload : st_q.count - 1'b1;
                st_d.out   = wave_level(st_q.op, st_d.count, st_q.reload);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.acc    <= ACC_WORD;
            st_q.op     <= OP_IDLE;
            st_q.reload <= '0;
            st_q.wr_hi  <= 1'b0;
            st_q.count  <= '0;
            st_q.run    <= 1'b0;
            st_q.out    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;
    assign acc_o   = st_q.acc;
    assign out_o   = st_q.out;

    // R3: each accepted tick takes exactly one off the count
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && tick_i && !prog_i && !wr_i &&
         (st_q.op == OP_TC || st_q.count != CNT_W'(1)))
        |=> (st_q.count == $past(st_q.count) - 1'b1));

    // R5: once the terminal-count output is high it stays high
    p_tc_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.op == OP_TC && st_q.run && st_q.out && !prog_i && !wr_i)
        |=> st_q.out);

    // R6: the rate generator's low slot lasts a single tick
    p_rate_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.op == OP_RATE && st_q.run && !st_q.out && tick_i &&
         st_q.reload != CNT_W'(1) && !prog_i && !wr_i)
        |=> st_q.out);

    // R13: a stopped channel holds its count
    p_idle_frozen_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !wr_i && !prog_i) |=> $stable(st_q.count));
endmodule

// File: rtl/ivt_readback.sv
module ivt_readback
    import ivt_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                prog_i,
    input  logic                latch_i,
    input  logic                rd_i,
    input  acc_e                acc_i,
    input  logic [2*BYTE_W-1:0] live_i,
    output logic [BYTE_W-1:0]   byte_o
);
    localparam int CNT_W = 2 * BYTE_W;

    typedef struct packed {
        logic             held;
        logic [CNT_W-1:0] snap;
        logic             rd_hi;
    } rb_state_t;

    rb_state_t rb_q, rb_d;
    logic [CNT_W-1:0] src;
    logic             pick_hi;

    assign src     = rb_q.held ? rb_q.snap : live_i;
    assign pick_hi = (acc_i == ACC_HI) || (acc_i == ACC_WORD && rb_q.rd_hi);
    assign byte_o  = pick_hi ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];

    always_comb begin
        rb_d = rb_q;
        if (prog_i) begin
            rb_d.held  = 1'b0;
            rb_d.rd_hi = 1'b0;
        end else begin
            if (rd_i) begin
                if (acc_i == ACC_WORD) begin
                    rb_d.rd_hi = !rb_q.rd_hi;
                    if (rb_q.rd_hi) rb_d.held = 1'b0;
                end else begin
                    rb_d.held = 1'b0;
                end
            end
            if (latch_i && !rb_q.held) begin
                rb_d.held = 1'b1;
                rb_d.snap = live_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_q.held  <= 1'b0;
            rb_q.snap  <= '0;
            rb_q.rd_hi <= 1'b0;
        end else begin
            rb_q <= rb_d;
        end
    end

    // R9: a held copy survives ticks and extra latch commands
    p_snap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_q.held && !prog_i && !rd_i) |=> (rb_q.held && $stable(rb_q.snap)));

    // R10: one read releases the copy in single-byte access
    p_single_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_q.held && rd_i && !prog_i && !latch_i && acc_i != ACC_WORD)
        |=> !rb_q.held);
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              cnt_tick,
    output logic [NUM_CH-1:0] tmr_out
);
    localparam int                CNT_W    = 2 * BYTE_W;
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_CH);

    logic                           wr_ctl;
    logic [NUM_CH-1:0]              prog;
    logic [NUM_CH-1:0]              latch;
    acc_e                           new_acc;
    op_e                            new_op;
    logic [NUM_CH-1:0][BYTE_W-1:0]  rb_byte;

    assign wr_ctl = bus_wr && (bus_addr == CTL_ADDR);

    ivt_ctrl_dec #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_dec (
        .wr_ctl_i (wr_ctl),
        .ctl_i    (bus_wdata[BYTE_W-1:1]),
        .prog_o   (prog),
        .latch_o  (latch),
        .acc_o    (new_acc),
        .op_o     (new_op)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic             ch_wr;
        logic             ch_rd;
        logic [CNT_W-1:0] ch_count;
        acc_e             ch_acc;

        assign ch_wr = bus_wr && (bus_addr == ADDR_W'(i));
        assign ch_rd = bus_rd && (bus_addr == ADDR_W'(i));

        ivt_channel #(.BYTE_W(BYTE_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (cnt_tick),
            .prog_i  (prog[i]),
            .acc_i   (new_acc),
            .op_i    (new_op),
            .wr_i    (ch_wr),
            .wdata_i (bus_wdata),
            .count_o (ch_count),
            .acc_o   (ch_acc),
            .out_o   (tmr_out[i])
        );

        ivt_readback #(.BYTE_W(BYTE_W)) u_rb (
            .clk     (clk),
            .rst_n   (rst_n),
            .prog_i  (prog[i]),
            .latch_i (latch[i]),
            .rd_i    (ch_rd),
            .acc_i   (ch_acc),
            .live_i  (ch_count),
            .byte_o  (rb_byte[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(i)) bus_rdata = rb_byte[i];
        end
    end
endmodule

// File: tb/ivt_timer_bench.sv
module ivt_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cnt_tick = 1'b0;
    logic [2:0] tmr_out;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    ivt_timer u_ivt_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_tick(cnt_tick), .tmr_out(tmr_out)
    );

    task automatic chk(input int act, input int exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        cnt_tick = 1'b1;
        repeat (n) @(negedge clk);
        cnt_tick = 1'b0;
    endtask

    task automatic t_reset;
        int v;
        chk(tmr_out, 3'b111, "R1 outputs after reset");
        ticks(3);
        rd(2'd0, v);
        chk(v, 0, "R1 channel 0 count after reset");
        chk(tmr_out, 3'b111, "R1 outputs after idle ticks");
    endtask

    task automatic t_mode0_zero;
        int lo, hi;
        wr(2'd3, 8'h30);
        chk(tmr_out[0], 0, "R5 control write drops output");
        chk(tmr_out[2:1], 2'b11, "R12 other outputs untouched");
        wr(2'd0, 8'h00); wr(2'd0, 8'h00);
        ticks(65535);
        chk(tmr_out[0], 0, "R8 low one tick before 65536");
        ticks(1);
        chk(tmr_out[0], 1, "R8 high at 65536 ticks");
        ticks(3);
        rd(2'd0, lo); rd(2'd0, hi);
        chk(lo, 8'hFD, "R5 keeps counting low byte");
        chk(hi, 8'hFF, "R5 keeps counting high byte");
        chk(tmr_out[0], 1, "R5 output stays high");
    endtask

    task automatic t_tick_on_load;
        wr(2'd3, 8'h30);
        wr(2'd0, 8'h03);
        cnt_tick = 1'b1;
        wr(2'd0, 8'h00);
        cnt_tick = 1'b0;
        ticks(2);
        chk(tmr_out[0], 0, "R3 tick with last byte not counted");
        ticks(1);
        chk(tmr_out[0], 1, "R3 high after third tick");
    endtask

    task automatic t_reorder;
        int v;
        wr(2'd3, 8'h30);
        wr(2'd0, 8'h55);
        wr(2'd3, 8'h30);
        wr(2'd0, 8'h05); wr(2'd0, 8'h00);
        rd(2'd0, v);
        chk(v, 8'h05, "R11 write order reset by control byte");
        wr(2'd3, 8'h30);
        rd(2'd0, v);
        chk(v, 8'h05, "R11 read order reset by control byte");
        wr(2'd0, 8'h05); wr(2'd0, 8'h00);
        ticks(4);
        chk(tmr_out[0], 0, "R5 low after N-1 ticks");
        ticks(1);
        chk(tmr_out[0], 1, "R5 high after N ticks");
    endtask

    task automatic t_rate;
        int errs = 0;
        wr(2'd3, 8'h74);
        wr(2'd1, 8'h04); wr(2'd1, 8'h00);
        chk(tmr_out[1], 1, "R6 high after load");
        for (int k = 1; k <= 8; k++) begin
            ticks(1);
            chk(tmr_out[1], ((k % 4) != 3) ? 1 : 0, $sformatf("R6 rate N=4 tick %0d", k));
        end
        wr(2'd3, 8'h75);
        wr(2'd1, 8'h12); wr(2'd1, 8'h00);
        for (int k = 1; k <= 18; k++) begin
            ticks(1);
            if (tmr_out[1] !== (((k % 18) != 17) ? 1'b1 : 1'b0)) errs++;
        end
        chk(errs, 0, "R2 bit 0 ignored, binary period 18");
    endtask

    task automatic t_square;
        wr(2'd3, 8'hB6);
        wr(2'd2, 8'h05); wr(2'd2, 8'h00);
        for (int k = 1; k <= 10; k++) begin
            ticks(1);
            chk(tmr_out[2], ((k % 5) < 3) ? 1 : 0, $sformatf("R7 square N=5 tick %0d", k));
        end
        wr(2'd3, 8'hBE);
        wr(2'd2, 8'h06); wr(2'd2, 8'h00);
        for (int k = 1; k <= 12; k++) begin
            ticks(1);
            chk(tmr_out[2], ((k % 6) < 3) ? 1 : 0, $sformatf("R7 square N=6 tick %0d", k));
        end
    endtask

    task automatic t_latch;
        int lo, hi;
        wr(2'd3, 8'h74);
        wr(2'd1, 8'hE8); wr(2'd1, 8'h03);
        ticks(10);
        wr(2'd3, 8'h40);
        ticks(5);
        wr(2'd3, 8'h40);
        ticks(3);
        rd(2'd1, lo); rd(2'd1, hi);
        chk(lo, 8'hDE, "R9 latched low byte");
        chk(hi, 8'h03, "R9 latched high byte");
        rd(2'd1, lo); rd(2'd1, hi);
        chk(lo, 8'hD6, "R10 live low after release");
        chk(hi, 8'h03, "R10 live high after release");
    endtask

    task automatic t_single_byte;
        int v;
        wr(2'd3, 8'h90);
        wr(2'd2, 8'h07);
        ticks(6);
        rd(2'd2, v);
        chk(v, 8'h01, "R4 low-only read");
        chk(tmr_out[2], 0, "R4 low-only still low");
        ticks(1);
        chk(tmr_out[2], 1, "R4 low-only high after 7");
        wr(2'd3, 8'hA0);
        wr(2'd2, 8'h01);
        rd(2'd2, v);
        chk(v, 8'h01, "R4 high-only read of 256");
        ticks(255);
        chk(tmr_out[2], 0, "R4 high-only low after 255");
        ticks(1);
        chk(tmr_out[2], 1, "R4 high-only high after 256");
        ticks(5);
        wr(2'd3, 8'h80);
        ticks(256);
        rd(2'd2, v);
        chk(v, 8'hFF, "R10 single-byte latched read");
        rd(2'd2, v);
        chk(v, 8'hFE, "R10 single read released copy");
    endtask

    task automatic t_unsupported;
        int a, b, c, d;
        wr(2'd3, 8'hF0);
        chk(tmr_out, 3'b111, "R2 select 11 ignored");
        wr(2'd3, 8'hB2);
        wr(2'd2, 8'h02); wr(2'd2, 8'h00);
        rd(2'd2, a); rd(2'd2, b);
        ticks(5);
        rd(2'd2, c); rd(2'd2, d);
        chk(tmr_out[2], 1, "R13 output held high");
        chk({c, d}, {a, b}, "R13 count never starts");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode0_zero();
        t_tick_on_load();
        t_reorder();
        t_rate();
        t_square();
        t_latch();
        t_single_byte();
        t_unsupported();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule